// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. It keeps the most recent `NTAPS` input samples in a tap buffer. On each clock of a computation it takes one bit from every buffered sample and uses the collected bits as the address into small constant tables. Each table word is the sum of the coefficients whose sample has a one in that bit. The word is shifted by the bit's weight and added into an accumulator. After `NBITS_IN` such steps the accumulator holds the full-precision filter output.

To keep the tables small, the taps are split into groups of `GROUP_TAPS`. Each group has its own `2^GROUP_TAPS`-word table, and the group words are added before the result is weighted. The table contents are worked out from the coefficient parameter during elaboration. The host presents one sample per frame of `SAMPLE_RATIO` clocks, which must be at least `NBITS_IN`. The arithmetic uses the first `NBITS_IN` clocks of a frame, and the datapath is idle for the rest.

The `SIGNED_MODE` parameter selects one of two number formats. With it cleared, samples and coefficients are unsigned. With it set, both are two's complement.

Top module: `fir_da_serial`

## Requirements
- R1: When `datao_valid` is high, `datao` equals the sum over k = 0..NTAPS-1 of `COEF[k] * x[k]`. Here x[0] is the newest accepted sample and x[k] is the sample accepted k samples earlier. Samples older than the last reset count as zero. The arithmetic is exact (no rounding, no truncation).
- R2: `datao_valid` is high for exactly one cycle. It rises on the `NBITS_IN`-th rising edge after the edge that accepted the sample. `datao` keeps its value from one valid pulse to the next.
- R3: `datai_en` is sampled only when the block is idle, or in the final clock of the current frame. Asserting it, with any `datai`, at any other time has no effect on later outputs. Accepted samples are at least `SAMPLE_RATIO` clocks apart.
- R4: Holding a new sample ready at the final clock of each frame gives one accepted sample every `SAMPLE_RATIO` clocks. Each result is correct, including when `SAMPLE_RATIO` equals `NBITS_IN` and the last bit step and the next sample fall on the same edge.
- R5: `datao` is `NBITS_IN + NBITS_COEF + ceil(log2(NTAPS)) - 1` bits wide. The largest inputs with all-positive coefficients give the exact sum, with no wrap.
- R6: The taps are split into ceil(NTAPS/GROUP_TAPS) table groups. Missing taps in a partial last group contribute zero. Results match R1 for any group size.
- R7: With `SIGNED_MODE` = 1, samples and coefficients are two's complement. The table word for the most significant bit is subtracted, and `datao` is two's complement.
- R8: While `rst_n` is low, `datao` is 0 and `datao_valid` is 0. After reset, the tap history is zero and the block is idle. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| datai_en | input | 1 | Offers `datai` as the next sample |
| datai | input | NBITS_IN | Input sample |
| datao_valid | output | 1 | One-cycle pulse when a result is ready |
| datao | output | NBITS_IN+NBITS_COEF+ceil(log2(NTAPS))-1 | Full-precision filter output |

## Verification
A unit impulse replays the coefficient list one tap at a time. This separates a wrong table word, group or tap order from an accumulation fault. An impulse of 128 isolates the top bit weight. A long run of 255 exposes any loss of output width. Alternating bit patterns and a pseudo-random stream, with junk enables inside frames and occasional idle gaps, separate wrong frame timing from wrong arithmetic. A second, small signed configuration has one sample per bit-step frame and two-tap groups with a partial last group. It is driven with every ordered pair of 4-bit values, which shows whether the subtraction of the top bit is correct.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } frame_st_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/fir_da_ctrl.sv
module fir_da_ctrl
    import fir_da_pkg::*;
#(
    parameter int NBITS_IN     = 8,
    parameter int SAMPLE_RATIO = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          datai_en,
    output logic                          accept,
    output logic                          calc,
    output logic                          first,
    output logic                          last,
    output logic [$clog2(NBITS_IN)-1:0]   phase
);
    localparam int SW = $clog2(SAMPLE_RATIO + 1);
    localparam int PW = $clog2(NBITS_IN);
    localparam logic [SW-1:0] SLOT_END = SW'(SAMPLE_RATIO - 1);
    localparam logic [SW-1:0] SLOT_MSB = SW'(NBITS_IN - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [SW-1:0]     slot;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;
    logic  frame_end;

    always_comb begin
        frame_end = (cur_q.st != ST_IDLE) && (cur_q.slot == SLOT_END);
        accept    = datai_en && ((cur_q.st == ST_IDLE) || frame_end);
        calc      = (cur_q.st == ST_CALC);
        first     = calc && (cur_q.slot == '0);
        last      = calc && (cur_q.slot == SLOT_MSB);
        phase     = cur_q.slot[PW-1:0];

        nxt_d = cur_q;
        if (accept) begin
            nxt_d.st   = ST_CALC;
            nxt_d.slot = '0;
        end else if (frame_end) begin
            nxt_d.st   = ST_IDLE;
            nxt_d.slot = '0;
        end else if (cur_q.st != ST_IDLE) begin
            nxt_d.slot = cur_q.slot + SW'(1);
            if (last) begin
                nxt_d.st = ST_HOLD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, slot: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/fir_da_tapbuf.sv
module fir_da_tapbuf #(
    parameter int NTAPS    = 13,
    parameter int NBITS_IN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 calc,
    input  logic [NBITS_IN-1:0]  datai,
    output logic [NTAPS-1:0]     plane
);
    typedef struct packed {
        logic [NTAPS-1:0][NBITS_IN-1:0] smp;
    } buf_s;

    buf_s cur_q, nxt_d, rot;

    always_comb begin
        // each step turns every sample right by one bit; after NBITS_IN
        // steps every sample is back in its natural bit order
        rot = cur_q;
        if (calc) begin
            for (int t = 0; t < NTAPS; t++) begin
                rot.smp[t] = {cur_q.smp[t][0], cur_q.smp[t][NBITS_IN-1:1]};
            end
        end

        nxt_d = rot;
        if (accept) begin
            for (int t = NTAPS - 1; t > 0; t--) begin
                nxt_d.smp[t] = rot.smp[t-1];
            end
            nxt_d.smp[0] = datai;
        end

        for (int t = 0; t < NTAPS; t++) begin
            plane[t] = cur_q.smp[t][0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/fir_da_lut.sv
module fir_da_lut #(
    parameter int NTAPS = 13,
    parameter int Q     = 4,
    parameter int BASE  = 0,
    parameter int LW    = 9,
    parameter int COEF [NTAPS] = '{default: 0}
) (
    input  logic [Q-1:0]   addr,
    output logic [LW-1:0]  word
);
    localparam int WORDS = 1 << Q;

    function automatic int word_fn(input int a);
        int s;
        s = 0;
        for (int j = 0; j < Q; j++) begin
            if (BASE + j < NTAPS) begin
                if (((a >> j) & 1) != 0) begin
                    s += COEF[BASE + j];
                end
            end
        end
        return s;
    endfunction

    logic [LW-1:0] rom [WORDS];

    for (genvar a = 0; a < WORDS; a++) begin : g_word
        localparam logic [LW-1:0] VAL = LW'(word_fn(a));
        assign rom[a] = VAL;
    end

    assign word = rom[addr];

endmodule

// File: rtl/fir_da_accum.sv
module fir_da_accum #(
    parameter int OUTW        = 17,
    parameter int PW          = 3,
    parameter int SIGNED_MODE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             calc,
    input  logic             first,
    input  logic             last,
    input  logic [PW-1:0]    phase,
    input  logic [OUTW-1:0]  term,
    output logic [OUTW-1:0]  datao,
    output logic             datao_valid
);
    typedef struct packed {
        logic [OUTW-1:0] acc;
        logic [OUTW-1:0] res;
        logic            vld;
    } acc_s;

    acc_s           cur_q, nxt_d;
    logic [OUTW-1:0] weighted;
    logic [OUTW-1:0] base;

    always_comb begin
        weighted = term << phase;
        base     = first ? '0 : cur_q.acc;

        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (calc) begin
            if (SIGNED_MODE != 0 && last) begin
                nxt_d.acc = base - weighted;
            end else begin
                nxt_d.acc = base + weighted;
            end
            if (last) begin
                nxt_d.res = nxt_d.acc;
                nxt_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign datao       = cur_q.res;
    assign datao_valid = cur_q.vld;

endmodule

// File: rtl/fir_da_serial.sv
module fir_da_serial
    import fir_da_pkg::*;
#(
    parameter int NTAPS        = 13,
    parameter int NBITS_IN     = 8,
    parameter int NBITS_COEF   = 6,
    parameter int GROUP_TAPS   = 4,
    parameter int SAMPLE_RATIO = 16,
    parameter int SIGNED_MODE  = 0,
    parameter int COEF [NTAPS] = '{8, 14, 21, 27, 31, 31, 27, 21, 14, 8, 4, 2, 1},
    localparam int OUTW = NBITS_IN + NBITS_COEF + $clog2(NTAPS) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 datai_en,
    input  logic [NBITS_IN-1:0]  datai,
    output logic                 datao_valid,
    output logic [OUTW-1:0]      datao
);
    localparam int NGRP   = ceil_div(NTAPS, GROUP_TAPS);
    localparam int PADW   = NGRP * GROUP_TAPS;
    localparam int PW     = $clog2(NBITS_IN);
    localparam int LW_RAW = NBITS_COEF + $clog2(GROUP_TAPS) + 1;
    localparam int LW     = (LW_RAW > OUTW) ? OUTW : LW_RAW;

    logic            accept, calc, first, last;
    logic [PW-1:0]   phase;
    logic [NTAPS-1:0] plane;
    logic [PADW-1:0] plane_pad;
    logic [LW-1:0]   grp_word [NGRP];
    logic [OUTW-1:0] term;

    fir_da_ctrl #(
        .NBITS_IN     (NBITS_IN),
        .SAMPLE_RATIO (SAMPLE_RATIO)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .datai_en (datai_en),
        .accept   (accept),
        .calc     (calc),
        .first    (first),
        .last     (last),
        .phase    (phase)
    );

    fir_da_tapbuf #(
        .NTAPS    (NTAPS),
        .NBITS_IN (NBITS_IN)
    ) u_tapbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .calc   (calc),
        .datai  (datai),
        .plane  (plane)
    );

    assign plane_pad = PADW'(plane);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        fir_da_lut #(
            .NTAPS (NTAPS),
            .Q     (GROUP_TAPS),
            .BASE  (g * GROUP_TAPS),
            .LW    (LW),
            .COEF  (COEF)
        ) u_lut (
            .addr (plane_pad[g*GROUP_TAPS +: GROUP_TAPS]),
            .word (grp_word[g])
        );
    end

    always_comb begin
        term = '0;
        for (int g = 0; g < NGRP; g++) begin
            term = term + OUTW'(signed'(grp_word[g]));
        end
    end

    fir_da_accum #(
        .OUTW        (OUTW),
        .PW          (PW),
        .SIGNED_MODE (SIGNED_MODE)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .calc        (calc),
        .first       (first),
        .last        (last),
        .phase       (phase),
        .term        (term),
        .datao       (datao),
        .datao_valid (datao_valid)
    );

endmodule

// File: rtl/fir_da_serial_chk.sv
module fir_da_serial_chk #(
    parameter int SAMPLE_RATIO = 16,
    parameter int OUTW         = 17
) (
    input logic            clk,
    input logic            rst_n,
    input logic            accept,
    input logic            calc,
    input logic            last,
    input logic            datao_valid,
    input logic [OUTW-1:0] datao
);
    int   gap_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (accept) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else if (gap_q < SAMPLE_RATIO) begin
            gap_q <= gap_q + 1;
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        datao_valid |=> !datao_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !datao_valid |-> $stable(datao));

    // R2
    result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        datao_valid |-> $past(calc && last));

    // R3
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seen_q) |-> (gap_q >= SAMPLE_RATIO - 1));

    // R3
    calc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calc && !last) |=> calc);

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (!datao_valid && datao == '0);
        end
    end

endmodule

bind fir_da_serial fir_da_serial_chk #(
    .SAMPLE_RATIO (SAMPLE_RATIO),
    .OUTW         (OUTW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .calc        (calc),
    .last        (last),
    .datao_valid (datao_valid),
    .datao       (datao)
);

// File: tb/tb_fir_da_serial.sv
module tb_fir_da_serial;
    localparam int U_NT = 13, U_NB = 8, U_NC = 6, U_Q = 4, U_SR = 16;
    localparam int U_OW = U_NB + U_NC + 4 - 1;
    localparam int S_NT = 5, S_NB = 4, S_NC = 5, S_Q = 2, S_SR = 4;
    localparam int S_OW = S_NB + S_NC + 3 - 1;
    localparam int U_CF [U_NT] = '{8, 14, 21, 27, 31, 31, 27, 21, 14, 8, 4, 2, 1};
    localparam int S_CF [S_NT] = '{-16, 15, -7, 3, 9};

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic en_u = 1'b0;
    logic [U_NB-1:0] d_u = '0;
    logic v_u;
    logic [U_OW-1:0] q_u;
    logic en_s = 1'b0;
    logic [S_NB-1:0] d_s = '0;
    logic v_s;
    logic [S_OW-1:0] q_s;

    int n_chk = 0, n_bad = 0;
    longint ncyc = 0;
    int hist_u [U_NT];
    int hist_s [S_NT];
    longint exp_u[$], at_u[$], exp_s[$], at_s[$];
    string tag_u[$], tag_s[$];
    longint last_u = 0, last_s = 0;

    always #10 clk = ~clk;

    fir_da_serial #(
        .NTAPS(U_NT), .NBITS_IN(U_NB), .NBITS_COEF(U_NC), .GROUP_TAPS(U_Q),
        .SAMPLE_RATIO(U_SR), .SIGNED_MODE(0), .COEF(U_CF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .datai_en(en_u), .datai(d_u),
        .datao_valid(v_u), .datao(q_u)
    );

    fir_da_serial #(
        .NTAPS(S_NT), .NBITS_IN(S_NB), .NBITS_COEF(S_NC), .GROUP_TAPS(S_Q),
        .SAMPLE_RATIO(S_SR), .SIGNED_MODE(1), .COEF(S_CF)
    ) dut_sgn (
        .clk(clk), .rst_n(rst_n), .datai_en(en_s), .datai(d_s),
        .datao_valid(v_s), .datao(q_s)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: compare every valid pulse, its latency and the hold between pulses
    always @(negedge clk) begin
        longint e, s;
        string t;
        ncyc++;
        if (!rst_n) begin
            last_u = 0;
            last_s = 0;
        end else begin
            if (v_u) begin
                if (exp_u.size() == 0) begin
                    check(1'b0, "R2 unexpected pulse", 1, 0);
                end else begin
                    e = exp_u.pop_front(); s = at_u.pop_front(); t = tag_u.pop_front();
                    check(longint'(q_u) == e, t, longint'(q_u), e);
                    check(ncyc - s == U_NB + 1, "R2 latency", ncyc - s, U_NB + 1);
                    last_u = longint'(q_u);
                end
            end else begin
                check(longint'(q_u) == last_u, "R2 hold", longint'(q_u), last_u);
            end
            if (v_s) begin
                if (exp_s.size() == 0) begin
                    check(1'b0, "R2 unexpected pulse", 1, 0);
                end else begin
                    e = exp_s.pop_front(); s = at_s.pop_front(); t = tag_s.pop_front();
                    check(longint'(q_s) == e, t, longint'(q_s), e);
                    check(ncyc - s == S_NB + 1, "R2 latency", ncyc - s, S_NB + 1);
                    last_s = longint'(q_s);
                end
            end else begin
                check(longint'(q_s) == last_s, "R2 hold", longint'(q_s), last_s);
            end
        end
    end

    task automatic send_u(input int x, input bit noise, input int gap, input string tag);
        longint y;
        @(negedge clk);
        en_u = 1'b1;
        d_u  = x[U_NB-1:0];
        @(posedge clk);
        for (int k = U_NT - 1; k > 0; k--) hist_u[k] = hist_u[k-1];
        hist_u[0] = x & 255;
        y = 0;
        for (int k = 0; k < U_NT; k++) y += longint'(U_CF[k]) * longint'(hist_u[k]);
        exp_u.push_back(y & ((64'sd1 <<< U_OW) - 1));
        at_u.push_back(ncyc);
        tag_u.push_back(tag);
        for (int k = 1; k < U_SR; k++) begin
            @(negedge clk);
            en_u = noise;
            d_u  = noise ? U_NB'(8'hA5 ^ k) : '0;
        end
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            en_u = 1'b0;
        end
    endtask

    task automatic send_s(input int x, input bit noise, input string tag);
        longint y;
        @(negedge clk);
        en_s = 1'b1;
        d_s  = x[S_NB-1:0];
        @(posedge clk);
        for (int k = S_NT - 1; k > 0; k--) hist_s[k] = hist_s[k-1];
        hist_s[0] = x;
        y = 0;
        for (int k = 0; k < S_NT; k++) y += longint'(S_CF[k]) * longint'(hist_s[k]);
        exp_s.push_back(y & ((64'sd1 <<< S_OW) - 1));
        at_s.push_back(ncyc);
        tag_s.push_back(tag);
        for (int k = 1; k < S_SR; k++) begin
            @(negedge clk);
            en_s = noise;
            d_s  = noise ? S_NB'(k + 5) : '0;
        end
    endtask

    task automatic flush();
        @(negedge clk);
        en_u = 1'b0;
        en_s = 1'b0;
        repeat (2 * U_SR + 4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int k = 0; k < U_NT; k++) hist_u[k] = 0;
        for (int k = 0; k < S_NT; k++) hist_s[k] = 0;
        #3 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(!v_u && q_u == '0, "R8", longint'(q_u), 0);
        check(!v_s && q_s == '0, "R8", longint'(q_s), 0);
        rst_n = 1'b1;

        // R1 / R6: impulse walks through every coefficient, partial last group
        send_u(1, 1'b0, 0, "R6");
        for (int i = 0; i < U_NT + 1; i++) send_u(0, 1'b0, 0, "R1");
        // R1: top bit weight alone
        send_u(128, 1'b0, 0, "R1");
        for (int i = 0; i < U_NT; i++) send_u(0, 1'b0, 0, "R1");
        // R5: full-scale inputs, largest sum
        for (int i = 0; i < U_NT + 2; i++) send_u(255, 1'b0, 0, "R5");
        // R1: alternating bit patterns
        for (int i = 0; i < 16; i++) send_u((i % 2 == 0) ? 8'hAA : 8'h55, 1'b0, 0, "R1");
        // R3 / R4: pseudo-random stream with in-frame junk enables and gaps
        lf = 16'hACE1;
        for (int i = 0; i < 100; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send_u(int'(lf[7:0]), (i % 3 == 0), (i % 5 == 0) ? 3 : 0,
                   (i % 3 == 0) ? "R3" : "R4");
        end
        flush();

        // R8: reset mid-run clears the tap history
        send_u(200, 1'b0, 0, "R1");
        send_u(77, 1'b0, 0, "R1");
        flush();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!v_u && q_u == '0, "R8", longint'(q_u), 0);
        for (int k = 0; k < U_NT; k++) hist_u[k] = 0;
        for (int k = 0; k < S_NT; k++) hist_s[k] = 0;
        rst_n = 1'b1;
        send_u(1, 1'b0, 0, "R8");
        for (int i = 0; i < 3; i++) send_u(0, 1'b0, 0, "R8");
        flush();

        // R7 / R4: signed, every ordered pair of 4-bit values, frames of NBITS_IN clocks
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                send_s(a, (b == 3), "R7");
                send_s(b, 1'b0, "R4");
            end
        end
        flush();

        check(exp_u.size() == 0 && exp_s.size() == 0, "R2 missing pulses",
              exp_u.size() + exp_s.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule